// File: doc/BRIEF.md
# Row-Buffered Dynamic Memory Array Model

This block is a synthesizable, cycle-level model of a 64K x 1 dynamic memory. The bits sit in a 256-row by 256-column array. Every access passes through a 256-bit row buffer. A single 8-bit address bus carries the row half of a 16-bit address first and the column half second. Two active-low strobes sample these halves. The strobes are ordinary synchronous inputs, and the block finds their edges by comparing each one with its value at the previous clock.

Lowering the row strobe opens a row. The row is copied into the buffer and cleared in the array, which models a destructive read. While the row strobe stays low, each falling column strobe reads or writes one bit of the buffer, so several columns can be reached in page mode. Raising the row strobe writes the whole buffer back in a single clock.

Each row has an age counter that counts clocks since the row was last opened or closed. A row that goes a full retention window without either event gets its error flag set. After that, the row's contents read as zero until it is opened and closed again.

Top module: `dram_row_model`

## Requirements
- R1: After reset, dout is 0, every bit of row_err is 0, and every array bit reads back as 0.
- R2: On a clock where ras_n is sampled low and was high at the previous clock, with no row open, addr is taken as the row number (the upper half of the 16-bit address). That row is copied into the row buffer and its array contents become all zero.
- R3: On a clock where cas_n is sampled low after being high, with a row open, ras_n low and wr_en=0, addr selects a column (the lower half of the 16-bit address). dout shows that buffer bit from this edge on and keeps it while cas_n stays low.
- R4: A falling CAS in the same conditions but with wr_en=1 loads din into the selected buffer bit. dout stays 0.
- R5: Whenever cas_n is sampled high, dout is 0 after that edge.
- R6: Several CAS cycles under one low ras_n reach different columns of the same open row, and each column keeps its own value.
- R7: The first clock that samples ras_n high while a row is open writes the buffer back to that row and closes it. A later reopen returns the written data.
- R8: A row that is not open and goes RETAIN_CYC clocks without being opened or closed gets its row_err bit set. The count restarts on open and on close and does not advance while the row is open.
- R9: Opening a row whose row_err bit is set loads an all-zero buffer. Closing that row clears its row_err bit and stores the buffer contents.
- R10: A falling CAS while no row is open, or on the same clock as the falling RAS, changes no stored bit and leaves dout 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| wr_en | input | 1 | 1 = column write, 0 = column read |
| addr | input | 8 | Shared row/column address bus |
| din | input | 1 | Write data |
| dout | output | 1 | Read data, 0 when not reading |
| row_err | output | 256 | Per-row retention error flags, bit i for row i |

## Verification
The hardest state to reach is an expired row that still holds data written before it expired. The bench writes a 1 into one row early and then refreshes a second row so that its deadline falls well after the first one. It then waits with a cycle count computed from the two close times. At that point it checks that only the first row is flagged, that the first row reads back as zero, and that closing it clears the flag. A row held open far longer than the window shows that the count stops while the row is open.

// File: rtl/dram_pkg.sv
package dram_pkg;
  typedef struct packed {
    logic open_stb;
    logic close_stb;
    logic rd_stb;
    logic wr_stb;
  } dram_evt_t;
endpackage

// File: rtl/dram_rst_sync.sv
module dram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dram_strobe_ctrl.sv
module dram_strobe_ctrl
  import dram_pkg::*;
#(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             wr_en,
  input  logic [ROW_W-1:0] addr,
  output dram_evt_t        evt,
  output logic             row_open,
  output logic [ROW_W-1:0] cur_row
);
  logic             ras_q, ras_d;
  logic             cas_q, cas_d;
  logic             open_q, open_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             ras_fall, cas_fall, col_ok;

  always_comb begin
    ras_fall      = ras_q & ~ras_n;
    cas_fall      = cas_q & ~cas_n;
    col_ok        = cas_fall & open_q & ~ras_n;
    evt.open_stb  = ras_fall & ~open_q;
    evt.close_stb = ras_n & open_q;
    evt.rd_stb    = col_ok & ~wr_en;
    evt.wr_stb    = col_ok & wr_en;
    ras_d         = ras_n;
    cas_d         = cas_n;
    open_d        = open_q;
    row_d         = row_q;
    if (evt.open_stb) begin
      open_d = 1'b1;
      row_d  = addr;
    end else if (evt.close_stb) begin
      open_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q  <= 1'b1;
      cas_q  <= 1'b1;
      open_q <= 1'b0;
      row_q  <= '0;
    end else begin
      ras_q  <= ras_d;
      cas_q  <= cas_d;
      open_q <= open_d;
      if (evt.open_stb) row_q <= row_d;
    end
  end

  assign row_open = open_q;
  assign cur_row  = row_q;

  assert_closed_when_ras_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ras_n |=> !row_open);
  assert_row_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt.open_stb |=> (row_open && cur_row == $past(addr)));
  assert_no_col_on_open_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt.open_stb |-> !(evt.rd_stb || evt.wr_stb));
endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array
  import dram_pkg::*;
#(
  parameter int ROW_W = 8,
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dram_evt_t        evt,
  input  logic             cas_n,
  input  logic [ROW_W-1:0] addr,
  input  logic [ROW_W-1:0] cur_row,
  input  logic             din,
  input  logic             row_expired,
  output logic             dout
);
  localparam int ROWS = 1 << ROW_W;
  localparam int COLS = 1 << COL_W;

  logic [COLS-1:0]  mem [ROWS];
  logic [COLS-1:0]  latch_q, latch_d;
  logic             dout_q, dout_d;
  logic [COL_W-1:0] col;

  assign col = addr[COL_W-1:0];

  always_comb begin
    latch_d = latch_q;
    if (evt.open_stb)     latch_d = row_expired ? '0 : mem[addr];
    else if (evt.wr_stb)  latch_d[col] = din;
    if (evt.rd_stb)       dout_d = latch_q[col];
    else if (evt.wr_stb)  dout_d = 1'b0;
    else if (cas_n)       dout_d = 1'b0;
    else                  dout_d = dout_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dout_q  <= 1'b0;
    end else begin
      if (evt.open_stb || evt.wr_stb) latch_q <= latch_d;
      dout_q <= dout_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem <= '{default: '0};
    end else if (evt.open_stb) begin
      mem[addr] <= '0;
    end else if (evt.close_stb) begin
      mem[cur_row] <= latch_q;
    end
  end

  assign dout = dout_q;

  assert_row_cleared_on_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt.open_stb |=> (mem[$past(addr)] == '0));
  assert_writeback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt.close_stb |=> (mem[$past(cur_row)] == $past(latch_q)));
  assert_dout_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cas_n |=> !dout);
  assert_write_dout_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt.wr_stb |=> !dout);
endmodule

// File: rtl/dram_retention.sv
module dram_retention #(
  parameter int ROW_W      = 8,
  parameter int RETAIN_CYC = 100000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  open_stb,
  input  logic                  close_stb,
  input  logic [ROW_W-1:0]      addr,
  input  logic [ROW_W-1:0]      cur_row,
  input  logic                  row_open,
  output logic [(1<<ROW_W)-1:0] row_err
);
  localparam int ROWS = 1 << ROW_W;
  localparam int AGE_W = (RETAIN_CYC > 2) ? $clog2(RETAIN_CYC) : 1;
  localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(RETAIN_CYC - 1);

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    logic [AGE_W-1:0] age_q, age_d;
    logic             err_q, err_d;
    logic             hold, restart;

    always_comb begin
      hold    = row_open && (cur_row == ROW_W'(i));
      restart = (open_stb && (addr == ROW_W'(i))) || (close_stb && hold);
      age_d   = age_q;
      err_d   = err_q;
      if (restart) begin
        age_d = '0;
        if (close_stb && hold) err_d = 1'b0;
      end else if (!hold && !err_q) begin
        if (age_q == AGE_LAST) err_d = 1'b1;
        else                   age_d = age_q + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        age_q <= '0;
        err_q <= 1'b0;
      end else begin
        age_q <= age_d;
        err_q <= err_d;
      end
    end

    assign row_err[i] = err_q;

    assert_open_row_age_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (age_q == '0));
    assert_age_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      age_q <= AGE_LAST);
  end

  assert_err_cleared_on_close_R9: assert property (@(posedge clk) disable iff (!rst_n)
    close_stb |=> !row_err[$past(cur_row)]);
endmodule

// File: rtl/dram_row_model.sv
module dram_row_model
  import dram_pkg::*;
#(
  parameter int ROW_W      = 8,
  parameter int COL_W      = 8,
  parameter int RETAIN_CYC = 100000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ras_n,
  input  logic                  cas_n,
  input  logic                  wr_en,
  input  logic [ROW_W-1:0]      addr,
  input  logic                  din,
  output logic                  dout,
  output logic [(1<<ROW_W)-1:0] row_err
);
  logic             rst_int_n;
  dram_evt_t        evt;
  logic             row_open;
  logic [ROW_W-1:0] cur_row;

  dram_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  dram_strobe_ctrl #(.ROW_W(ROW_W)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .ras_n(ras_n), .cas_n(cas_n),
    .wr_en(wr_en), .addr(addr), .evt(evt), .row_open(row_open),
    .cur_row(cur_row)
  );

  dram_cell_array #(.ROW_W(ROW_W), .COL_W(COL_W)) u_array (
    .clk(clk), .rst_n(rst_int_n), .evt(evt), .cas_n(cas_n),
    .addr(addr), .cur_row(cur_row), .din(din),
    .row_expired(row_err[addr]), .dout(dout)
  );

  dram_retention #(.ROW_W(ROW_W), .RETAIN_CYC(RETAIN_CYC)) u_ret (
    .clk(clk), .rst_n(rst_int_n), .open_stb(evt.open_stb),
    .close_stb(evt.close_stb), .addr(addr), .cur_row(cur_row),
    .row_open(row_open), .row_err(row_err)
  );
endmodule

// File: tb/dram_row_model_test.sv
module dram_row_model_test;
  localparam int CLK_PERIOD = 10;
  localparam int LIM = 600;
  localparam int NR = 256;

  logic clk = 1'b0;
  logic rst_n, ras_n, cas_n, wr_en, din;
  logic [7:0] addr;
  logic dout;
  logic [NR-1:0] row_err;

  int errors = 0, checks = 0, cyc = 0;
  bit model_on = 0, done = 0;

  logic [NR-1:0] m_mem [NR];
  logic [NR-1:0] m_latch, m_err;
  int m_age [NR];
  logic m_dout, m_ras_q, m_cas_q, m_open;
  int m_row;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_row_model #(.RETAIN_CYC(LIM)) uut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .wr_en(wr_en),
    .addr(addr), .din(din), .dout(dout), .row_err(row_err)
  );

  task automatic check(input bit ok, input string tag, input logic [NR-1:0] act, input logic [NR-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Reference model, updated on every rising edge once reset is released
  always @(posedge clk) begin
    cyc++;
    if (model_on) begin
      bit op, cl, rd, wr;
      op = m_ras_q && !ras_n && !m_open;
      cl = ras_n && m_open;
      rd = m_cas_q && !cas_n && m_open && !ras_n && !wr_en;
      wr = m_cas_q && !cas_n && m_open && !ras_n && wr_en;
      for (int r = 0; r < NR; r++) begin
        if (!(m_open && r == m_row) && !(op && r == int'(addr)) && !m_err[r]) begin
          if (m_age[r] == LIM - 1) m_err[r] = 1'b1;
          else m_age[r]++;
        end
      end
      if (rd) m_dout = m_latch[addr];
      else if (wr || cas_n) m_dout = 1'b0;
      if (op) begin
        m_latch = m_err[addr] ? '0 : m_mem[addr];
        m_mem[addr] = '0;
        m_age[addr] = 0;
        m_row = addr;
        m_open = 1'b1;
      end
      if (wr) m_latch[addr] = din;
      if (cl) begin
        m_mem[m_row] = m_latch;
        m_err[m_row] = 1'b0;
        m_age[m_row] = 0;
        m_open = 1'b0;
      end
      m_ras_q = ras_n;
      m_cas_q = cas_n;
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      check(dout === m_dout, "R3 dout vs model", NR'(dout), NR'(m_dout));
      check(row_err === m_err, "R8 row_err vs model", row_err, m_err);
    end
  end

  task automatic open_row(input int r);
    addr = 8'(r); ras_n = 1'b0; @(negedge clk);
  endtask

  task automatic close_row();
    ras_n = 1'b1; @(negedge clk); @(negedge clk);
  endtask

  task automatic col_write(input int c, input bit b, input string tag);
    addr = 8'(c); wr_en = 1'b1; din = b; cas_n = 1'b0; @(negedge clk);
    check(dout === 1'b0, tag, NR'(dout), '0);
    cas_n = 1'b1; wr_en = 1'b0; @(negedge clk);
  endtask

  task automatic col_read(input int c, input bit exp, input string tag);
    addr = 8'(c); wr_en = 1'b0; cas_n = 1'b0; @(negedge clk);
    check(dout === exp, tag, NR'(dout), NR'(exp));
    @(negedge clk);
    check(dout === exp, {tag, " held"}, NR'(dout), NR'(exp));
    cas_n = 1'b1; @(negedge clk);
    check(dout === 1'b0, "R5 dout after CAS high", NR'(dout), '0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int t40, t12;
    rst_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; wr_en = 1'b0; din = 1'b0; addr = '0;
    m_latch = '0; m_err = '0; m_dout = 1'b0; m_ras_q = 1'b1; m_cas_q = 1'b1;
    m_open = 1'b0; m_row = 0;
    for (int r = 0; r < NR; r++) begin m_mem[r] = '0; m_age[r] = 0; end
    repeat (3) @(negedge clk);
    check(dout === 1'b0, "R1 dout in reset", NR'(dout), '0);
    check(row_err === '0, "R1 row_err in reset", row_err, '0);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    model_on = 1;

    // R1: array reads back zero
    open_row(3); col_read(7, 1'b0, "R1 fresh array bit"); close_row();

    // setup for R9: row 0x40 col 3 = 1
    open_row(8'h40); col_write(3, 1'b1, "R4 dout zero on write"); close_row();
    t40 = cyc;

    // R2/R3/R4/R6: page mode on row 0x12
    open_row(8'h12);
    col_write(5, 1'b1, "R4 write col5");
    col_write(6, 1'b0, "R4 write col6");
    col_write(200, 1'b1, "R6 write col200");
    col_read(5, 1'b1, "R3 read col5");
    col_read(200, 1'b1, "R6 read col200");
    col_read(6, 1'b0, "R6 read col6");
    close_row();

    // R7: reopen keeps written data
    open_row(8'h12); col_read(5, 1'b1, "R7 reopen col5"); col_read(200, 1'b1, "R7 reopen col200");
    close_row();

    // R10: stray CAS with no row open
    addr = 8'd5; wr_en = 1'b1; din = 1'b0; cas_n = 1'b0; @(negedge clk);
    check(dout === 1'b0, "R10 stray CAS dout", NR'(dout), '0);
    cas_n = 1'b1; wr_en = 1'b0; @(negedge clk);
    // R10: CAS on same edge as RAS
    addr = 8'h12; ras_n = 1'b0; cas_n = 1'b0; wr_en = 1'b1; @(negedge clk);
    check(dout === 1'b0, "R10 CAS with RAS edge", NR'(dout), '0);
    cas_n = 1'b1; wr_en = 1'b0; @(negedge clk);
    col_read(5, 1'b1, "R10 col5 untouched");
    close_row();

    // R8: refresh 0x12 well after 0x40, wait for 0x40 to expire only
    repeat (50) @(negedge clk);
    open_row(8'h12); close_row();
    t12 = cyc;
    while (cyc < t40 + LIM + 30) @(negedge clk);
    check(row_err[8'h40] === 1'b1, "R8 row 0x40 expired", NR'(row_err[8'h40]), 1);
    check(row_err[8'h12] === 1'b0, "R8 row 0x12 refreshed", NR'(row_err[8'h12]), 0);
    check(t12 + LIM > cyc, "R8 schedule margin", NR'(t12), NR'(cyc));

    // R9: expired row reads zero, close clears flag
    open_row(8'h40); col_read(3, 1'b0, "R9 expired row reads zero"); close_row();
    check(row_err[8'h40] === 1'b0, "R9 flag cleared on close", NR'(row_err[8'h40]), 0);
    open_row(8'h40); col_read(3, 1'b0, "R9 written back zero"); close_row();

    // R8: row held open does not age
    open_row(8'h55); close_row();
    check(row_err[8'h55] === 1'b0, "R9 0x55 cleared", NR'(row_err[8'h55]), 0);
    open_row(8'h55); col_write(1, 1'b1, "R4 write 0x55");
    repeat (LIM + 100) @(negedge clk);
    check(row_err[8'h55] === 1'b0, "R8 open row not aging", NR'(row_err[8'h55]), 0);
    col_read(1, 1'b1, "R8 open row data kept");
    close_row();
    open_row(8'h55); col_read(1, 1'b1, "R7 0x55 after hold"); close_row();

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule